// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the transfer address and transfer count for four DMA channels. Each channel has a base address, a current address, a base count and a current count, all 16 bits wide. A CPU write port loads a base register and its current register together. A per-channel mode port selects one of two address directions, increment or decrement, and turns autoinitialize on or off.

A transfer sequencer drives the unit. For each transfer it pulses `xfer_en` with the serving channel on `act_ch`. The unit then moves that channel's current address by one and lowers its current count by one. A count that steps below zero wraps to FFFFh. The wrap marks terminal count and ends service on that channel. An external end-of-process input, active low, can also end service on the active channel while service runs.

At end of service there are two outcomes. With autoinitialize on, the current registers reload from the base registers. With autoinitialize off, the unit requests that the channel be masked and latches a terminal-count status bit. In memory-to-memory operation, channel 0 is the source and channel 1 is the destination, and channel 1's count alone decides when the operation ends.

Top module: `dma_addr_count_unit`

## Requirements
- R1: A CPU write with `cpu_wr_sel`=0 loads the base and current address of channel `cpu_wr_ch`, and with `cpu_wr_sel`=1 loads the base and current count. The new value shows on `cur_addr`/`cur_count` in the cycle after the write edge, whenever `act_ch` selects that channel.
- R2: A transfer step (`xfer_en`=1) lowers the active channel's current count by one. It raises the current address by one when the channel's mode bit `dec` is 0, and lowers it by one when `dec` is 1.
- R3: A step taken while the current count is 0000h is terminal count. `tc_pulse` is high for exactly the one cycle after that edge.
- R4: With autoinitialize off, a terminal count leaves the current count at FFFFh. For one cycle it raises the channel's bit in `mask_set`, and it sets that channel's bit in `tc_status`.
- R5: With autoinitialize on, end of service reloads the current address and count from the base registers. `mask_set` stays 0 and `tc_status` is unchanged.
- R6: `eop_n`=0 while `svc_active`=1 ends service on channel `act_ch` as in R4/R5, without a step and without `tc_pulse`.
- R7: Every end of service raises the channel's bit in `req_clr` for one cycle. This bit clears that channel's pending request.
- R8: With `mem2mem`=1, a step moves the addresses of channels 0 and 1 and lowers only channel 1's count. Channel 1's terminal count ends service on both channels: `mask_set` and `tc_status` bits 1:0 are set when autoinitialize is off. No `tc_pulse` comes before that wrap.
- R9: `status_rd`=1 clears all `tc_status` bits at the next edge. A bit set by an end of service at the same edge stays set.
- R10: After reset, every register is 0, every mode is increment without autoinitialize, and `tc_status`, `mask_set`, `req_clr` and `tc_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_ch | input | 2 | Channel addressed by a register or mode write |
| cpu_wr_sel | input | 1 | 0 = address pair, 1 = count pair |
| cpu_wr_data | input | 16 | Value written to base and current |
| mode_wr_en | input | 1 | Mode write strobe for channel `cpu_wr_ch` |
| mode_dec | input | 1 | Mode value: 1 = decrement address |
| mode_autoinit | input | 1 | Mode value: 1 = autoinitialize |
| mem2mem | input | 1 | Memory-to-memory operation on channels 0 and 1 |
| act_ch | input | 2 | Channel being served, and the channel shown on the outputs |
| svc_active | input | 1 | Service in progress on `act_ch` |
| xfer_en | input | 1 | One transfer step |
| eop_n | input | 1 | External end of process, active low |
| status_rd | input | 1 | Status read, clears the TC bits |
| cur_addr | output | 16 | Current address of `act_ch` |
| cur_count | output | 16 | Current count of `act_ch` |
| tc_pulse | output | 1 | Terminal-count pulse (internal end of process) |
| tc_status | output | 4 | Latched per-channel TC bits |
| mask_set | output | 4 | One-cycle request to mask channels |
| req_clr | output | 4 | One-cycle request to clear pending requests |

## Verification
The bench steps a count through 0000h and expects FFFFh, one `tc_pulse` cycle, and the right side effects. An off-by-one decrementor would fire a step early or late, and a design that tested for 0001h would end one transfer short. Autoinitialize runs back to back with a normal end. A design that masked autoinitialized channels, or set their TC bit, is caught through `mask_set` and `tc_status`. An external end of process on an autoinitialize channel must reload without `tc_pulse`. In memory-to-memory operation, channel 0's count must stay fixed while both addresses move, and both channels must end together. A status read in the same cycle as a new end must keep the new bit; a design that lets the clear win would lose that terminal count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } dmac_sel_e;
endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_addr,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  input  logic         step_addr,
  input  logic         step_cnt,
  input  logic         dec,
  input  logic         reload,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] cur_cnt,
  output logic         cnt_zero
);
  logic [W-1:0] base_a_q, base_a_d, cur_a_q, cur_a_d;
  logic [W-1:0] base_c_q, base_c_d, cur_c_q, cur_c_d;

  always_comb begin
    base_a_d = base_a_q;
    cur_a_d  = cur_a_q;
    if (wr_addr) begin
      base_a_d = wr_data;
      cur_a_d  = wr_data;
    end else if (reload) begin
      cur_a_d = base_a_q;
    end else if (step_addr) begin
      cur_a_d = dec ? cur_a_q - W'(1) : cur_a_q + W'(1);
    end
  end

  always_comb begin
    base_c_d = base_c_q;
    cur_c_d  = cur_c_q;
    if (wr_cnt) begin
      base_c_d = wr_data;
      cur_c_d  = wr_data;
    end else if (reload) begin
      cur_c_d = base_c_q;
    end else if (step_cnt) begin
      cur_c_d = cur_c_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      cur_a_q  <= '0;
      base_c_q <= '0;
      cur_c_q  <= '0;
    end else begin
      base_a_q <= base_a_d;
      cur_a_q  <= cur_a_d;
      base_c_q <= base_c_d;
      cur_c_q  <= cur_c_d;
    end
  end

  assign cur_addr = cur_a_q;
  assign cur_cnt  = cur_c_q;
  assign cnt_zero = (cur_c_q == '0);

  // R5
  reload_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_addr) |=> cur_a_q == $past(base_a_q));

  // R4
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt && !reload && !wr_cnt && cur_c_q == '0) |=> cur_c_q == '1);

  // R2
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_addr && !reload && !wr_addr && !dec) |=> cur_a_q == $past(cur_a_q) + W'(1));
endmodule

// File: rtl/dmac_end_ctrl.sv
module dmac_end_ctrl #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] end_vec,
  input  logic [NCH-1:0] autoinit,
  input  logic           wrap_any,
  input  logic           status_rd,
  output logic [NCH-1:0] reload,
  output logic [NCH-1:0] tc_status,
  output logic [NCH-1:0] mask_set,
  output logic [NCH-1:0] req_clr,
  output logic           tc_pulse
);
  logic [NCH-1:0] tc_q, tc_d, mset_q, mset_d, rclr_q, rclr_d;
  logic           tcp_q, tcp_d;
  logic [NCH-1:0] plain_end;

  always_comb begin
    plain_end = end_vec & ~autoinit;
    reload    = end_vec & autoinit;
    tc_d      = (status_rd ? '0 : tc_q) | plain_end;
    mset_d    = plain_end;
    rclr_d    = end_vec;
    tcp_d     = wrap_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= '0;
      mset_q <= '0;
      rclr_q <= '0;
      tcp_q  <= 1'b0;
    end else begin
      tc_q   <= tc_d;
      mset_q <= mset_d;
      rclr_q <= rclr_d;
      tcp_q  <= tcp_d;
    end
  end

  assign tc_status = tc_q;
  assign mask_set  = mset_q;
  assign req_clr   = rclr_q;
  assign tc_pulse  = tcp_q;

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && end_vec == '0) |=> tc_q == '0);

  // R4
  tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|plain_end) |=> ((tc_q & $past(plain_end)) == $past(plain_end)));

  // R5
  autoinit_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_vec == autoinit && |end_vec) |=> mset_q == '0);
endmodule

// File: rtl/dma_addr_count_unit.sv
module dma_addr_count_unit #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 16,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_wr_en,
  input  logic [CHW-1:0] cpu_wr_ch,
  input  logic           cpu_wr_sel,
  input  logic [W-1:0]   cpu_wr_data,
  input  logic           mode_wr_en,
  input  logic           mode_dec,
  input  logic           mode_autoinit,
  input  logic           mem2mem,
  input  logic [CHW-1:0] act_ch,
  input  logic           svc_active,
  input  logic           xfer_en,
  input  logic           eop_n,
  input  logic           status_rd,
  output logic [W-1:0]   cur_addr,
  output logic [W-1:0]   cur_count,
  output logic           tc_pulse,
  output logic [NCH-1:0] tc_status,
  output logic [NCH-1:0] mask_set,
  output logic [NCH-1:0] req_clr
);
  import dmac_pkg::*;

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [NCH-1:0] dec_q, dec_d, ai_q, ai_d;
  logic [NCH-1:0] step_addr, step_cnt, wr_addr, wr_cnt, cnt_zero;
  logic [NCH-1:0] wrap, end_vec, reload;
  logic [W-1:0]   ch_addr [NCH];
  logic [W-1:0]   ch_cnt  [NCH];
  logic           ext_end;

  assign ext_end = svc_active && !eop_n;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_me;
      logic in_pair;
      assign sel_me  = (act_ch == CHW'(i));
      assign in_pair = (i < 2);

      always_comb begin
        dec_d[i] = dec_q[i];
        ai_d[i]  = ai_q[i];
        if (mode_wr_en && cpu_wr_ch == CHW'(i)) begin
          dec_d[i] = mode_dec;
          ai_d[i]  = mode_autoinit;
        end
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          dec_q[i] <= 1'b0;
          ai_q[i]  <= 1'b0;
        end else if (mode_wr_en) begin
          dec_q[i] <= dec_d[i];
          ai_q[i]  <= ai_d[i];
        end
      end

      always_comb begin
        wr_addr[i] = cpu_wr_en && cpu_wr_ch == CHW'(i) && cpu_wr_sel == SEL_ADDR;
        wr_cnt[i]  = cpu_wr_en && cpu_wr_ch == CHW'(i) && cpu_wr_sel == SEL_CNT;
        if (mem2mem) begin
          step_addr[i] = xfer_en && in_pair;
          step_cnt[i]  = xfer_en && (i == 1);
        end else begin
          step_addr[i] = xfer_en && sel_me;
          step_cnt[i]  = xfer_en && sel_me;
        end
        wrap[i] = step_cnt[i] && cnt_zero[i];
      end

      dmac_chan_regs #(.W(W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .wr_addr   (wr_addr[i]),
        .wr_cnt    (wr_cnt[i]),
        .wr_data   (cpu_wr_data),
        .step_addr (step_addr[i]),
        .step_cnt  (step_cnt[i]),
        .dec       (dec_q[i]),
        .reload    (reload[i]),
        .cur_addr  (ch_addr[i]),
        .cur_cnt   (ch_cnt[i]),
        .cnt_zero  (cnt_zero[i])
      );
    end
  endgenerate

  always_comb begin
    end_vec = '0;
    if (mem2mem) begin
      end_vec[0] = wrap[1] || ext_end;
      end_vec[1] = wrap[1] || ext_end;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        end_vec[k] = wrap[k] || (ext_end && act_ch == CHW'(k));
      end
    end
  end

  dmac_end_ctrl #(.NCH(NCH)) u_end (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .end_vec   (end_vec),
    .autoinit  (ai_q),
    .wrap_any  (|wrap),
    .status_rd (status_rd),
    .reload    (reload),
    .tc_status (tc_status),
    .mask_set  (mask_set),
    .req_clr   (req_clr),
    .tc_pulse  (tc_pulse)
  );

  assign cur_addr  = ch_addr[act_ch];
  assign cur_count = ch_cnt[act_ch];

  // R3
  tc_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer_en && !mem2mem && cur_count == '0) |=> tc_pulse);

  // R3
  tc_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tc_pulse |-> $past(xfer_en));

  // R7
  end_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_end && !mem2mem) |=> req_clr[$past(act_ch)]);

  // R8
  m2m_no_early_tc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer_en && mem2mem && !cnt_zero[1]) |=> !tc_pulse);
endmodule

// File: tb/tb_dma_addr_count_unit.sv
module tb_dma_addr_count_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, cpu_wr_sel, mode_wr_en, mode_dec, mode_autoinit;
  logic [1:0]  cpu_wr_ch, act_ch;
  logic [15:0] cpu_wr_data;
  logic        mem2mem, svc_active, xfer_en, eop_n, status_rd;
  logic [15:0] cur_addr, cur_count;
  logic        tc_pulse;
  logic [3:0]  tc_status, mask_set, req_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_addr_count_unit dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_ch(cpu_wr_ch),
    .cpu_wr_sel(cpu_wr_sel), .cpu_wr_data(cpu_wr_data), .mode_wr_en(mode_wr_en),
    .mode_dec(mode_dec), .mode_autoinit(mode_autoinit), .mem2mem(mem2mem),
    .act_ch(act_ch), .svc_active(svc_active), .xfer_en(xfer_en), .eop_n(eop_n),
    .status_rd(status_rd), .cur_addr(cur_addr), .cur_count(cur_count),
    .tc_pulse(tc_pulse), .tc_status(tc_status), .mask_set(mask_set), .req_clr(req_clr)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] ch, input logic sel, input logic [15:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_ch = ch; cpu_wr_sel = sel; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] ch, input logic dec, input logic ai);
    @(negedge clk);
    mode_wr_en = 1'b1; cpu_wr_ch = ch; mode_dec = dec; mode_autoinit = ai;
    @(negedge clk);
    mode_wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); xfer_en = 1'b1;
    @(negedge clk); xfer_en = 1'b0;
  endtask

  task automatic ext_eop(input logic rd);
    @(negedge clk); svc_active = 1'b1; eop_n = 1'b0; status_rd = rd;
    @(negedge clk); svc_active = 1'b0; eop_n = 1'b1; status_rd = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "cur_addr", cur_addr, 16'h0000);
    chk("R10", "cur_count", cur_count, 16'h0000);
    chk("R10", "tc_status", 16'(tc_status), 16'h0000);
    chk("R10", "mask_set", 16'(mask_set), 16'h0000);
    chk("R10", "req_clr/tc_pulse", {11'b0, tc_pulse, req_clr}, 16'h0000);
  endtask

  task automatic t_load_step();
    act_ch = 2'd2;
    wr_reg(2'd2, 1'b0, 16'h1234);
    wr_reg(2'd2, 1'b1, 16'h0003);
    chk("R1", "addr after write", cur_addr, 16'h1234);
    chk("R1", "count after write", cur_count, 16'h0003);
    step();
    chk("R2", "inc addr", cur_addr, 16'h1235);
    chk("R2", "count down", cur_count, 16'h0002);
    chk("R3", "no tc on nonzero", {15'b0, tc_pulse}, 16'h0000);
    wr_mode(2'd3, 1'b1, 1'b0);
    act_ch = 2'd3;
    wr_reg(2'd3, 1'b0, 16'h0010);
    wr_reg(2'd3, 1'b1, 16'h0008);
    step();
    chk("R2", "dec addr", cur_addr, 16'h000F);
    chk("R2", "dec count", cur_count, 16'h0007);
  endtask

  task automatic t_tc_normal();
    act_ch = 2'd2;
    wr_reg(2'd2, 1'b1, 16'h0000);
    step();
    chk("R3", "tc_pulse after wrap", {15'b0, tc_pulse}, 16'h0001);
    chk("R4", "count wraps", cur_count, 16'hFFFF);
    chk("R4", "mask_set", 16'(mask_set), 16'h0004);
    chk("R4", "tc_status", 16'(tc_status), 16'h0004);
    chk("R7", "req_clr", 16'(req_clr), 16'h0004);
    @(negedge clk);
    chk("R3", "tc_pulse one cycle", {15'b0, tc_pulse}, 16'h0000);
    chk("R4", "mask_set one cycle", 16'(mask_set), 16'h0000);
    rd_status();
    chk("R9", "status read clears", 16'(tc_status), 16'h0000);
  endtask

  task automatic t_autoinit();
    wr_mode(2'd1, 1'b0, 1'b1);
    act_ch = 2'd1;
    wr_reg(2'd1, 1'b0, 16'h0100);
    wr_reg(2'd1, 1'b1, 16'h0001);
    step();
    chk("R2", "ai first step addr", cur_addr, 16'h0101);
    step();
    chk("R5", "reload count", cur_count, 16'h0001);
    chk("R5", "reload addr", cur_addr, 16'h0100);
    chk("R3", "ai tc_pulse", {15'b0, tc_pulse}, 16'h0001);
    chk("R5", "no mask_set", 16'(mask_set), 16'h0000);
    chk("R5", "tc_status unchanged", 16'(tc_status), 16'h0000);
    chk("R7", "ai req_clr", 16'(req_clr), 16'h0002);
  endtask

  task automatic t_ext_eop();
    act_ch = 2'd1;
    step();
    chk("R2", "ch1 moved", cur_addr, 16'h0101);
    ext_eop(1'b0);
    chk("R6", "eop reload addr", cur_addr, 16'h0100);
    chk("R6", "eop reload count", cur_count, 16'h0001);
    chk("R6", "eop no tc_pulse", {15'b0, tc_pulse}, 16'h0000);
    chk("R6", "eop ai no mask", 16'(mask_set), 16'h0000);
    act_ch = 2'd3;
    ext_eop(1'b0);
    chk("R6", "eop mask_set ch3", 16'(mask_set), 16'h0008);
    chk("R7", "eop req_clr ch3", 16'(req_clr), 16'h0008);
    chk("R6", "eop tc_status ch3", 16'(tc_status), 16'h0008);
    chk("R6", "eop count kept", cur_count, 16'h0007);
    act_ch = 2'd2;
    ext_eop(1'b1);
    chk("R9", "set wins over read", 16'(tc_status), 16'h0004);
    rd_status();
  endtask

  task automatic t_m2m();
    wr_mode(2'd0, 1'b0, 1'b0);
    wr_mode(2'd1, 1'b0, 1'b0);
    wr_reg(2'd0, 1'b0, 16'h2000);
    wr_reg(2'd0, 1'b1, 16'h0005);
    wr_reg(2'd1, 1'b0, 16'h3000);
    wr_reg(2'd1, 1'b1, 16'h0001);
    mem2mem = 1'b1;
    act_ch = 2'd0;
    step();
    chk("R8", "src addr moved", cur_addr, 16'h2001);
    chk("R8", "src count fixed", cur_count, 16'h0005);
    chk("R8", "no early tc", {15'b0, tc_pulse}, 16'h0000);
    act_ch = 2'd1;
    #1;
    chk("R8", "dst addr moved", cur_addr, 16'h3001);
    chk("R8", "dst count down", cur_count, 16'h0000);
    step();
    chk("R8", "tc on ch1 wrap", {15'b0, tc_pulse}, 16'h0001);
    chk("R8", "both masked", 16'(mask_set), 16'h0003);
    chk("R8", "both tc bits", 16'(tc_status), 16'h0003);
    chk("R8", "dst addr", cur_addr, 16'h3002);
    mem2mem = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_wr_sel = 0; mode_wr_en = 0; mode_dec = 0; mode_autoinit = 0;
    cpu_wr_ch = 0; act_ch = 0; cpu_wr_data = 0; mem2mem = 0; svc_active = 0;
    xfer_en = 0; eop_n = 1; status_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_step();
    t_tc_normal();
    t_autoinit();
    t_ext_eop();
    t_m2m();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule